// File: doc/BRIEF.md
# SPI Shift Engine with Selectable Transfer Direction

This block moves words between a transmit FIFO, a serial line pair and a receive FIFO for an SPI controller. It works either as the bus master, where it generates the serial clock and chip select itself, or as a slave, where it follows a clock and select driven by another device. Data is shifted most significant bit first, with output bits changing on the falling clock edge and input bits sampled on the rising edge. The frame length can be set anywhere from 4 to 16 bits.

As master, a two-bit direction field chooses what happens to each frame. In full duplex, words are popped, sent, and the reply is pushed. In send-only, the replies are dropped. In receive-only, the data line is held low and nothing is popped. In receive-only the burst is paced by a run input rather than by the transmit FIFO. As slave, the direction field has no effect and every frame is handled in full duplex. A separate enable bit lets the slave keep its data line undriven.

A master burst keeps chip select low from the first frame to the last. It ends at a frame boundary once there is no more work. The surrounding controller uses `busy` to see when a burst is in progress.

Top module: `spi_xfer_engine`

## Requirements
- R1: After reset `cs_n` is 1, `sclk` is 0, `busy` is 0, and neither `txf_pop` nor `rxf_push` is asserted.
- R2: In master mode with `cfg_mode` 2'b00, each word popped from the transmit FIFO appears on `txd` MSB first, one bit per `sclk` rising edge. Each frame received on `rxd` is pushed exactly once, one cycle after its last sampled bit, with the bits above the frame size cleared.
- R3: In master mode with `cfg_mode` 2'b01, frames are popped and sent exactly as in R2, but `rxf_push` never asserts.
- R4: In master mode with `cfg_mode` 2'b10, `txd` stays 0 and `txf_pop` never asserts. Received frames are pushed as in R2. A new frame starts at a frame boundary only while `rx_run` is 1.
- R5: In master mode, `cfg_mode` 2'b11 behaves identically to 2'b00.
- R6: The frame size is `cfg_frame_bits`, clamped to the range 4 to 16 (values below 4 give 4, values above 16 give 16).
- R7: In master mode `cs_n` falls when a burst starts and stays low across frame boundaries. It rises exactly once per burst, together with the last falling `sclk` edge, after a frame ends with no further work. `sclk` is never high while `cs_n` is high.
- R8: In master mode `busy` equals the inverse of `cs_n` on every cycle.
- R9: In slave mode (`cfg_is_master` 0), `cfg_mode` is ignored. Every frame clocked in on `s_sclk` while `s_cs_n` is low is pushed. With the output enabled, each frame sends the next transmit FIFO word, or zero if the FIFO is empty.
- R10: In slave mode with `cfg_slave_oe` 0, `txd_oe` and `txd` stay 0 and no word is popped, while received frames are still pushed.
- R11: In master mode `sclk` has a period of 2*HALF_DIV clock cycles throughout a burst, including across frame boundaries.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_mode | input | 2 | Master transfer direction: 00 duplex, 01 send-only, 10 receive-only, 11 as 00 |
| cfg_frame_bits | input | BITS_W | Requested frame size in bits |
| cfg_is_master | input | 1 | 1 selects master operation, 0 selects slave operation |
| cfg_slave_oe | input | 1 | Slave data output enable |
| rx_run | input | 1 | Keeps a receive-only master burst going |
| txf_empty | input | 1 | Transmit FIFO has no word |
| txf_data | input | DATA_W | Head word of the transmit FIFO |
| txf_pop | output | 1 | Consumes the head word of the transmit FIFO |
| rxf_push | output | 1 | Writes `rxf_data` into the receive FIFO |
| rxf_data | output | DATA_W | Received frame, right aligned |
| sclk | output | 1 | Serial clock driven as master |
| cs_n | output | 1 | Chip select driven as master |
| s_sclk | input | 1 | Serial clock from a remote master, synchronous to `clk` |
| s_cs_n | input | 1 | Chip select from a remote master, synchronous to `clk` |
| txd | output | 1 | Serial data out |
| txd_oe | output | 1 | Output enable for `txd` |
| rxd | input | 1 | Serial data in |
| busy | output | 1 | A burst is in progress |

## Verification
A wrong bit counter or a bad frame size clamp shows up on the first frame. The word captured from `txd` is misaligned, and the pushed word has the wrong width or arrives one edge early or late. A control state that wrongly continues or stops a burst shows up at the end of that burst, as an extra or missing chip-select release, a wrong pop count, or leftover expected frames. A direction decode fault shows up within one frame, as a push in send-only mode or a pop or a high `txd` in receive-only mode.

// File: rtl/spi_xfer_pkg.sv
package spi_xfer_pkg;

  typedef enum logic [1:0] {
    XM_DUPLEX  = 2'b00,
    XM_TX_ONLY = 2'b01,
    XM_RX_ONLY = 2'b10,
    XM_RESVD   = 2'b11
  } xfer_mode_e;

  typedef enum logic [1:0] {
    MS_IDLE = 2'b00,
    MS_RUN  = 2'b01,
    MS_LAST = 2'b10
  } mst_state_e;

  // Effective frame size: the request pulled into [lo, hi].
  function automatic int clamp_bits(int req, int lo, int hi);
    if (req < lo) return lo;
    if (req > hi) return hi;
    return req;
  endfunction

  // A slave keeps every frame; a master drops them only in send-only mode.
  function automatic logic mode_keeps_rx(logic [1:0] mode, logic is_master);
    return !is_master || (xfer_mode_e'(mode) != XM_TX_ONLY);
  endfunction

  // Only a master in receive-only mode silences its data line.
  function automatic logic mode_silent_tx(logic [1:0] mode, logic is_master);
    return is_master && (xfer_mode_e'(mode) == XM_RX_ONLY);
  endfunction

endpackage

// File: rtl/spi_xfer_clkgen.sv
module spi_xfer_clkgen #(
  parameter int HALF_DIV = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic sclk,
  output logic ev_rise,
  output logic ev_fall
);
  localparam int CW = $clog2(HALF_DIV + 1);

  logic [CW-1:0] div_cnt;
  logic          tick;

  assign tick    = run && (div_cnt == CW'(HALF_DIV - 1));
  assign ev_rise = tick && !sclk;
  assign ev_fall = tick && sclk;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_cnt <= '0;
      sclk    <= 1'b0;
    end else if (!run) begin
      div_cnt <= '0;
      sclk    <= 1'b0;
    end else if (tick) begin
      div_cnt <= '0;
      sclk    <= !sclk;
    end else begin
      div_cnt <= div_cnt + 1'b1;
    end
  end
endmodule

// File: rtl/spi_xfer_slv_edges.sv
module spi_xfer_slv_edges (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic s_sclk,
  input  logic s_cs_n,
  output logic ev_rise,
  output logic ev_fall,
  output logic ev_start
);
  logic sck_q, cs_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_q <= 1'b0;
      cs_q  <= 1'b1;
    end else begin
      sck_q <= s_sclk;
      cs_q  <= s_cs_n;
    end
  end

  assign ev_rise  = en && !s_cs_n && !sck_q && s_sclk;
  assign ev_fall  = en && !s_cs_n && sck_q && !s_sclk;
  assign ev_start = en && cs_q && !s_cs_n;
endmodule

// File: rtl/spi_xfer_shifter.sv
module spi_xfer_shifter #(
  parameter int DATA_W = 16,
  parameter int BITS_W = $clog2(DATA_W + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [BITS_W-1:0] nbits,
  input  logic              clear,
  input  logic              load,
  input  logic [DATA_W-1:0] load_word,
  input  logic              ev_sample,
  input  logic              ev_shift,
  input  logic              rxd,
  output logic              tx_bit,
  output logic              frame_end,
  output logic [DATA_W-1:0] rx_word
);
  logic [DATA_W-1:0] tx_sh, rx_sh, rx_next, top_bit, frame_mask;
  logic [BITS_W-1:0] bit_cnt;

  assign top_bit    = DATA_W'(1) << (nbits - 1'b1);
  assign frame_mask = (top_bit << 1) - DATA_W'(1);
  assign tx_bit     = |(tx_sh & top_bit);
  assign frame_end  = ev_sample && (bit_cnt == nbits - 1'b1);
  assign rx_next    = {rx_sh[DATA_W-2:0], rxd};
  assign rx_word    = rx_next & frame_mask;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bit_cnt <= '0;
      tx_sh   <= '0;
      rx_sh   <= '0;
    end else begin
      if (clear || frame_end) bit_cnt <= '0;
      else if (ev_sample)     bit_cnt <= bit_cnt + 1'b1;

      if (load)                                 tx_sh <= load_word;
      else if (ev_shift && (bit_cnt != '0))     tx_sh <= tx_sh << 1;

      if (ev_sample) rx_sh <= rx_next;
    end
  end
endmodule

// File: rtl/spi_xfer_engine.sv
module spi_xfer_engine
  import spi_xfer_pkg::*;
#(
  parameter int DATA_W   = 16,
  parameter int MIN_BITS = 4,
  parameter int HALF_DIV = 2,
  parameter int BITS_W   = $clog2(DATA_W + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        cfg_mode,
  input  logic [BITS_W-1:0] cfg_frame_bits,
  input  logic              cfg_is_master,
  input  logic              cfg_slave_oe,
  input  logic              rx_run,
  input  logic              txf_empty,
  input  logic [DATA_W-1:0] txf_data,
  output logic              txf_pop,
  output logic              rxf_push,
  output logic [DATA_W-1:0] rxf_data,
  output logic              sclk,
  output logic              cs_n,
  input  logic              s_sclk,
  input  logic              s_cs_n,
  output logic              txd,
  output logic              txd_oe,
  input  logic              rxd,
  output logic              busy
);
  mst_state_e        st;
  logic [BITS_W-1:0] nbits;
  logic              silent_tx, keeps_rx, m_has_work;
  logic              m_rise, m_fall, m_start, m_cont, m_load;
  logic              s_rise, s_fall, s_start, s_load;
  logic              ev_sample, ev_shift, sh_clear, load, pop_en;
  logic              tx_bit, frame_end;
  logic [DATA_W-1:0] rx_word, load_word;

  // Decoded configuration.
  assign nbits      = BITS_W'(clamp_bits(int'(cfg_frame_bits), MIN_BITS, DATA_W));
  assign silent_tx  = mode_silent_tx(cfg_mode, cfg_is_master);
  assign keeps_rx   = mode_keeps_rx(cfg_mode, cfg_is_master);
  assign m_has_work = silent_tx ? rx_run : !txf_empty;

  // Frame events.
  assign m_start = cfg_is_master && (st == MS_IDLE) && m_has_work;
  assign m_cont  = (st == MS_RUN) && frame_end && m_has_work;
  assign m_load  = m_start || m_cont;
  assign s_load  = !cfg_is_master && (s_start || (frame_end && !s_cs_n));

  assign load      = m_load || s_load;
  assign pop_en    = cfg_is_master ? (m_load && !silent_tx)
                                   : (s_load && cfg_slave_oe && !txf_empty);
  assign txf_pop   = pop_en;
  assign load_word = pop_en ? txf_data : '0;

  assign ev_sample = cfg_is_master ? m_rise : s_rise;
  assign ev_shift  = cfg_is_master ? m_fall : s_fall;
  assign sh_clear  = cfg_is_master ? (st == MS_IDLE) : s_cs_n;

  spi_xfer_clkgen #(.HALF_DIV(HALF_DIV)) u_clkgen (
    .clk(clk), .rst_n(rst_n), .run(st != MS_IDLE),
    .sclk(sclk), .ev_rise(m_rise), .ev_fall(m_fall)
  );

  spi_xfer_slv_edges u_slv_edges (
    .clk(clk), .rst_n(rst_n), .en(!cfg_is_master),
    .s_sclk(s_sclk), .s_cs_n(s_cs_n),
    .ev_rise(s_rise), .ev_fall(s_fall), .ev_start(s_start)
  );

  spi_xfer_shifter #(.DATA_W(DATA_W), .BITS_W(BITS_W)) u_shifter (
    .clk(clk), .rst_n(rst_n), .nbits(nbits), .clear(sh_clear),
    .load(load), .load_word(load_word),
    .ev_sample(ev_sample), .ev_shift(ev_shift), .rxd(rxd),
    .tx_bit(tx_bit), .frame_end(frame_end), .rx_word(rx_word)
  );

  // Master burst control and chip select.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st   <= MS_IDLE;
      cs_n <= 1'b1;
    end else begin
      unique case (st)
        MS_IDLE: if (m_start) begin
          st   <= MS_RUN;
          cs_n <= 1'b0;
        end
        MS_RUN:  if (frame_end && !m_has_work) st <= MS_LAST;
        MS_LAST: if (m_fall) begin
          st   <= MS_IDLE;
          cs_n <= 1'b1;
        end
        default: st <= MS_IDLE;
      endcase
    end
  end

  // Receive FIFO write, one cycle after the last sampled bit.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rxf_push <= 1'b0;
      rxf_data <= '0;
    end else begin
      rxf_push <= frame_end && keeps_rx;
      if (frame_end) rxf_data <= rx_word;
    end
  end

  assign txd_oe = cfg_is_master ? 1'b1 : (cfg_slave_oe && !s_cs_n);
  assign txd    = cfg_is_master ? ((st != MS_IDLE) && !silent_tx && tx_bit)
                                : (txd_oe && tx_bit);
  assign busy   = (st != MS_IDLE) || (!cfg_is_master && !s_cs_n);
endmodule

// File: rtl/spi_xfer_checks.sv
module spi_xfer_checks (
  input logic       clk,
  input logic       rst_n,
  input logic [1:0] cfg_mode,
  input logic       cfg_is_master,
  input logic       cfg_slave_oe,
  input logic       sclk,
  input logic       cs_n,
  input logic       txd,
  input logic       txd_oe,
  input logic       txf_pop,
  input logic       rxf_push,
  input logic       busy,
  input logic       frame_end
);
  assert_push_after_frame_R2: assert property (@(posedge clk) disable iff (!rst_n)
    rxf_push |-> $past(frame_end));

  assert_single_pop_R2: assert property (@(posedge clk) disable iff (!rst_n)
    txf_pop |=> !txf_pop);

  assert_no_push_tx_only_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_is_master && cfg_mode == 2'b01 && $past(cfg_is_master) && $past(cfg_mode) == 2'b01)
      |-> !rxf_push);

  assert_quiet_rx_only_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_is_master && cfg_mode == 2'b10) |-> (!txf_pop && !txd));

  assert_sclk_inside_cs_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_is_master && sclk) |-> !cs_n);

  assert_busy_tracks_cs_R8: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_is_master |-> (busy == !cs_n));

  assert_slave_silent_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_is_master && !cfg_slave_oe) |-> (!txd_oe && !txd && !txf_pop));
endmodule

bind spi_xfer_engine spi_xfer_checks u_checks (
  .clk(clk), .rst_n(rst_n), .cfg_mode(cfg_mode), .cfg_is_master(cfg_is_master),
  .cfg_slave_oe(cfg_slave_oe), .sclk(sclk), .cs_n(cs_n), .txd(txd), .txd_oe(txd_oe),
  .txf_pop(txf_pop), .rxf_push(rxf_push), .busy(busy), .frame_end(frame_end)
);

// File: tb/spi_xfer_engine_bench.sv
module spi_xfer_engine_bench;
  localparam int HALF = 2;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  cfg_mode = 2'b00;
  logic [4:0]  cfg_frame_bits = 5'd8;
  logic        cfg_is_master = 1'b1;
  logic        cfg_slave_oe = 1'b1;
  logic        rx_run = 1'b0;
  logic        txf_empty = 1'b1;
  logic [15:0] txf_data = 16'h0;
  logic        txf_pop, rxf_push, sclk, cs_n, txd, txd_oe, busy;
  logic [15:0] rxf_data;
  logic        s_sclk = 1'b0, s_cs_n = 1'b1, rxd = 1'b0;

  always #10 clk = ~clk;

  spi_xfer_engine #(.DATA_W(16), .MIN_BITS(4), .HALF_DIV(HALF)) u_spi_xfer_engine (
    .clk(clk), .rst_n(rst_n), .cfg_mode(cfg_mode), .cfg_frame_bits(cfg_frame_bits),
    .cfg_is_master(cfg_is_master), .cfg_slave_oe(cfg_slave_oe), .rx_run(rx_run),
    .txf_empty(txf_empty), .txf_data(txf_data), .txf_pop(txf_pop),
    .rxf_push(rxf_push), .rxf_data(rxf_data), .sclk(sclk), .cs_n(cs_n),
    .s_sclk(s_sclk), .s_cs_n(s_cs_n), .txd(txd), .txd_oe(txd_oe), .rxd(rxd), .busy(busy)
  );

  int vectors = 0, miscompares = 0, cyc = 0;
  int pop_cnt = 0, push_cnt = 0, cs_rises = 0, busy_err = 0, per_err = 0;
  int eb = 8;
  string cur_tag = "R2";
  logic [15:0] txq[$], exp_tx[$], exp_rx[$], slv_q[$];

  function automatic int eff(int fb);
    return (fb < 4) ? 4 : ((fb > 16) ? 16 : fb);
  endfunction

  function automatic logic [15:0] mk(int n);
    return 16'((32'h1 << n) - 1);
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    vectors++;
    if (!ok) begin
      miscompares++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic refresh_tx();
    txf_empty = (txq.size() == 0);
    txf_data  = txf_empty ? 16'h0 : txq[0];
  endtask

  // Transmit FIFO model: a pop seen in a cycle takes effect after that edge.
  logic pop_seen = 1'b0;
  always @(negedge clk) begin
    if (pop_seen) begin
      pop_cnt++;
      if (txq.size() != 0) void'(txq.pop_front());
      else check(1'b0, "R2", "pop from empty fifo", 1, 0);
      refresh_tx();
    end
    #1;
    pop_seen = txf_pop;
  end

  // Scoreboard monitor for receive FIFO writes.
  always @(negedge clk) begin
    if (rst_n && rxf_push) begin
      push_cnt++;
      if (exp_rx.size() == 0) check(1'b0, "R3", "unexpected rx push", int'(rxf_data), 0);
      else begin
        logic [15:0] e;
        e = exp_rx.pop_front();
        check(rxf_data == e, cur_tag, "rx word", int'(rxf_data), int'(e));
      end
    end
  end

  // Remote slave model used while the engine is master.
  int bi = 0, last_rise = -1;
  logic have = 1'b0, last_txd = 1'b0, prev_sclk = 1'b0, prev_cs = 1'b1;
  logic [15:0] rxw = 16'h0, cap = 16'h0;
  always @(negedge clk) begin
    cyc++;
    if (rst_n && cfg_is_master) begin
      if (!prev_cs && cs_n) cs_rises++;
      if (busy != !cs_n) busy_err++;
      if (cs_n) begin
        bi = 0; have = 1'b0; cap = 16'h0; last_rise = -1;
      end else begin
        if (!have) begin
          rxw = (slv_q.size() != 0) ? slv_q.pop_front() : 16'h0;
          have = 1'b1;
        end
        if (!prev_sclk && sclk) begin
          if (last_rise >= 0 && (cyc - last_rise) != 2 * HALF) per_err++;
          last_rise = cyc;
          cap = {cap[14:0], last_txd};
          bi++;
          if (bi == eb) begin
            if (exp_tx.size() == 0) check(1'b0, cur_tag, "extra tx frame", int'(cap), 0);
            else begin
              logic [15:0] e;
              e = exp_tx.pop_front();
              check((cap & mk(eb)) == e, cur_tag, "tx frame on txd", int'(cap & mk(eb)), int'(e));
            end
            cap = 16'h0; bi = 0;
            rxw = (slv_q.size() != 0) ? slv_q.pop_front() : 16'h0;
          end
        end
        if (!sclk) last_txd = txd;
        rxd = rxw[eb-1-bi];
      end
    end
    prev_sclk = sclk;
    prev_cs   = cs_n;
  end

  // Watchdog.
  always @(negedge clk) begin
    if (cyc > 150000) begin
      check(1'b0, "watchdog", "run did not finish", cyc, 150000);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  task automatic begin_test(input logic master, input logic [1:0] mode,
                            input logic [4:0] fb, input string tag);
    @(negedge clk);
    cfg_is_master = master; cfg_mode = mode; cfg_frame_bits = fb;
    eb = eff(int'(fb)); cur_tag = tag;
    cs_rises = 0; busy_err = 0; per_err = 0;
    slv_q.delete(); exp_tx.delete(); exp_rx.delete();
  endtask

  task automatic end_master_checks(input string tag, input int pops_exp, input int p0);
    check(exp_tx.size() == 0, tag, "tx frames not seen", exp_tx.size(), 0);
    check(exp_rx.size() == 0, tag, "rx pushes missing", exp_rx.size(), 0);
    check(pop_cnt - p0 == pops_exp, tag, "pop count", pop_cnt - p0, pops_exp);
    check(cs_rises == 1, "R7", "cs_n releases per burst", cs_rises, 1);
    check(cs_n == 1'b1, "R7", "cs_n idle after burst", int'(cs_n), 1);
    check(busy_err == 0, "R8", "busy vs cs_n mismatches", busy_err, 0);
    check(per_err == 0, "R11", "sclk period errors", per_err, 0);
  endtask

  task automatic master_burst(input logic [1:0] mode, input logic [4:0] fb, input int n,
                              input logic [15:0] seed, input string tag);
    int p0;
    begin_test(1'b1, mode, fb, tag);
    p0 = pop_cnt;
    for (int k = 0; k < n; k++) begin
      logic [15:0] w, r;
      w = seed ^ 16'(k * 16'h3b5d);
      r = ~w ^ 16'h5a96;
      txq.push_back(w);
      exp_tx.push_back(w & mk(eb));
      slv_q.push_back(r);
      if (mode != 2'b01) exp_rx.push_back(r & mk(eb));
    end
    refresh_tx();
    while (!busy) @(negedge clk);
    while (busy) @(negedge clk);
    repeat (3) @(negedge clk);
    end_master_checks(tag, n, p0);
  endtask

  task automatic rxonly_burst();
    int p0, base;
    begin_test(1'b1, 2'b10, 5'd12, "R4");
    p0 = pop_cnt;
    for (int k = 0; k < 2; k++) begin
      logic [15:0] r;
      r = 16'hc3a5 ^ 16'(k * 16'h0f0f);
      slv_q.push_back(r);
      exp_rx.push_back(r & mk(eb));
      exp_tx.push_back(16'h0);
    end
    base = push_cnt;
    rx_run = 1'b1;
    while (push_cnt == base) @(negedge clk);
    rx_run = 1'b0;
    while (busy) @(negedge clk);
    repeat (3) @(negedge clk);
    end_master_checks("R4", 0, p0);
  endtask

  task automatic slave_burst(input logic [1:0] mode, input logic oe, input logic [4:0] fb,
                             input int n, input int fifo_words, input logic [15:0] seed,
                             input string tag);
    int p0, oe_err, pops_exp;
    logic [15:0] sw[8];
    begin_test(1'b0, mode, fb, tag);
    cfg_slave_oe = oe;
    p0 = pop_cnt; oe_err = 0;
    for (int k = 0; k < fifo_words; k++) begin
      sw[k] = seed + 16'(k * 16'h1111);
      txq.push_back(sw[k]);
    end
    refresh_tx();
    s_cs_n = 1'b0;
    repeat (3) @(negedge clk);
    for (int k = 0; k < n; k++) begin
      logic [15:0] send, got, e;
      send = ~seed ^ 16'(k * 16'h2468);
      exp_rx.push_back(send & mk(eb));
      e = (oe && k < fifo_words) ? (sw[k] & mk(eb)) : 16'h0;
      got = 16'h0;
      for (int i = eb - 1; i >= 0; i--) begin
        rxd = send[i];
        repeat (2) @(negedge clk);
        got[i] = txd;
        if (txd_oe != oe) oe_err++;
        s_sclk = 1'b1;
        repeat (3) @(negedge clk);
        s_sclk = 1'b0;
      end
      check(got == e, tag, "slave tx frame", int'(got), int'(e));
    end
    repeat (3) @(negedge clk);
    s_cs_n = 1'b1; rxd = 1'b0;
    repeat (3) @(negedge clk);
    pops_exp = oe ? ((n < fifo_words) ? n : fifo_words) : 0;
    check(exp_rx.size() == 0, "R9", "slave rx pushes missing", exp_rx.size(), 0);
    check(pop_cnt - p0 == pops_exp, tag, "slave pop count", pop_cnt - p0, pops_exp);
    check(oe_err == 0, "R10", "txd_oe mismatches", oe_err, 0);
    txq.delete();
    refresh_tx();
    cfg_slave_oe = 1'b1;
  endtask

  initial begin
    repeat (4) @(negedge clk);
    // R1: reset state while still in reset and just after release.
    check(cs_n == 1'b1 && sclk == 1'b0 && busy == 1'b0, "R1", "pins in reset",
          {29'd0, cs_n, sclk, busy}, 4);
    rst_n = 1'b1;
    @(negedge clk);
    check(rxf_push == 1'b0 && txf_pop == 1'b0, "R1", "no fifo strobes after reset",
          {30'd0, rxf_push, txf_pop}, 0);

    master_burst(2'b00, 5'd8,  3, 16'ha5c3, "R2");
    master_burst(2'b00, 5'd16, 2, 16'h8001, "R6");
    master_burst(2'b01, 5'd8,  3, 16'h3c5a, "R3");
    rxonly_burst();
    master_burst(2'b11, 5'd6,  2, 16'h0f2d, "R5");
    master_burst(2'b00, 5'd2,  2, 16'h00b7, "R6");
    master_burst(2'b00, 5'd31, 1, 16'hf00d, "R6");
    slave_burst(2'b01, 1'b1, 5'd8,  2, 2, 16'h5ac3, "R9");
    slave_burst(2'b10, 1'b1, 5'd10, 2, 1, 16'h1e87, "R9");
    slave_burst(2'b00, 1'b0, 5'd8,  2, 2, 16'h7711, "R10");

    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule